// File: doc/BRIEF.md
# Shared-Pool Multi-Queue Ingress Buffer

This block buffers incoming data for several logical ports in one payload memory. The memory is cut into fixed-size slots, and each slot has an index that is also its address. No port owns a fixed share of the slots. Every accepted write takes the slot at the front of a single free chain, stores the word there, and links the slot onto the tail of the addressed port's queue. A serviced read takes the slot at the front of the named port's queue, returns its word one cycle later, and links that slot back onto the tail of the free chain. A single next-pointer memory holds the free chain and all of the per-port chains.

The queues are elastic. A port that receives a burst can occupy every slot in the pool. When another port drains, its slots go back to the shared pool and any port can reuse them. Each port has an enable input and a start-level input, and both can change while other ports carry traffic. A disabled port accepts no new data, but its existing contents can still be read. A port's read side stays closed until its occupancy reaches the port's start level. It then stays open until the port is empty. Each port reports its occupancy and an empty flag. A sticky flag records any write that was lost because the pool had no free slot.

Top module: `mq_shared_buf`

## Requirements
- R1: After reset every port reports occupancy 0 and empty, the overflow flag is 0, rd_valid is 0, and all NUM_BUFS slots are free.
- R2: Each port returns its data in write order. A serviced read request in cycle t gives rd_valid=1 and the word in rd_data after the next rising edge.
- R3: A write to an enabled port when no slot is free is dropped and sets the overflow flag. The flag stays 1 until reset, and no port's contents change.
- R4: A single port can hold all NUM_BUFS slots at once. Slots released by one port are reused by writes to any other port.
- R5: A read request to a port with occupancy 0 gives rd_valid=0 and changes no occupancy.
- R6: After a port has been empty, its read requests are ignored (rd_valid=0, occupancy unchanged) until its occupancy reaches its start level. Reads are then serviced until the port is empty again. A start level of 0 acts as 1. The level is an unsigned field of width clog2(NUM_BUFS+1) at bit offset port*width of start_lvl.
- R7: A write to a port whose port_en bit is 0 is ignored. It does not set overflow and does not affect other ports. Reads from that port are still serviced.
- R8: A write and a read in the same cycle both complete, including when both name the same port and that port holds one word. When the pool is full, the write in such a cycle is dropped, because a slot freed in a cycle is available only from the next cycle.
- R9: port_occ for each port equals its accepted writes minus its serviced reads. The field layout is the same as start_lvl. port_empty[p] is 1 exactly when that occupancy is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| port_en | input | NUM_PORTS | Per-port write enable |
| start_lvl | input | NUM_PORTS*CW | Per-port read start level, CW=clog2(NUM_BUFS+1) |
| wr_valid | input | 1 | Write request |
| wr_port | input | PW | Target port of the write |
| wr_data | input | DATA_W | Write word |
| rd_req | input | 1 | Read request |
| rd_port | input | PW | Port to read from |
| rd_valid | output | 1 | rd_data holds a word read out |
| rd_data | output | DATA_W | Read word |
| port_empty | output | NUM_PORTS | Per-port empty flag |
| port_occ | output | NUM_PORTS*CW | Per-port occupancy |
| overflow | output | 1 | Sticky lost-write flag |

## Verification
The hardest states to reach from the ports are at the edges of the pool: the free chain with zero or one slot while a slot is released in the same cycle, and a port queue with one word that is read and written in the same cycle. Both force a pointer update to bypass a next-pointer entry that is being written in that same cycle. Directed sequences fill the whole pool into one port and then run same-cycle read and write at full and near-full pool. After that, a seeded random phase with changing start levels and port enables keeps the pool moving between full and empty. A bench model of per-port queues checks every cycle.

// File: rtl/mqb_pkg.sv
// Package: shared helpers for the shared-pool multi-queue buffer.
// Assumes: callers pass positive element counts.
package mqb_pkg;

    // Index width for n elements, never below one bit.
    function automatic int bits_for(input int n);
        return (n <= 2) ? 1 : $clog2(n);
    endfunction

    // Width of a counter that must reach n inclusive.
    function automatic int count_bits(input int n);
        return $clog2(n + 1);
    endfunction

endpackage

// File: rtl/mqb_link_ram.sv
// Next-pointer memory shared by the free chain and all port chains.
// Two write ports (free chain, port chains) and two combinational reads.
// Assumes: the two write ports never target the same entry in one cycle.
module mqb_link_ram #(
    parameter int NB = 16,
    parameter int IW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wa_en,
    input  logic [IW-1:0] wa_addr,
    input  logic [IW-1:0] wa_data,
    input  logic          wb_en,
    input  logic [IW-1:0] wb_addr,
    input  logic [IW-1:0] wb_data,
    input  logic [IW-1:0] ra_addr,
    output logic [IW-1:0] ra_data,
    input  logic [IW-1:0] rb_addr,
    output logic [IW-1:0] rb_data
);

    logic [IW-1:0] nxt [NB];

    // Reset chains every slot to its successor, otherwise applies link writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NB; i++) begin
                nxt[i] <= (i == NB - 1) ? '0 : IW'(i + 1);
            end
        end else begin
            if (wa_en) nxt[wa_addr] <= wa_data;
            if (wb_en) nxt[wb_addr] <= wb_data;
        end
    end

    // Combinational successor lookups.
    always_comb begin
        ra_data = nxt[ra_addr];
        rb_data = nxt[rb_addr];
    end

endmodule

// File: rtl/mqb_payload_ram.sv
// Payload storage: one data word per slot, one write and one read port.
// Assumes: write and read never name the same slot in one cycle
// (a slot is either free or queued, never both).
module mqb_payload_ram #(
    parameter int NB = 16,
    parameter int DW = 16,
    parameter int IW = 4
) (
    input  logic          clk,
    input  logic          we,
    input  logic [IW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [IW-1:0] raddr,
    output logic [DW-1:0] rdata
);

    logic [DW-1:0] mem [NB];

    // Stores the word of an accepted write.
    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    // Combinational read of the slot at a queue head.
    always_comb rdata = mem[raddr];

endmodule

// File: rtl/mqb_free_pool.sv
// Free chain control: head, tail and count of unused slots.
// Pops the head for a write and pushes a released slot at the tail.
// Assumes: pop is only raised while cnt is non-zero.
module mqb_free_pool #(
    parameter int NB = 16,
    parameter int IW = 4,
    parameter int CW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pop,
    input  logic          push,
    input  logic [IW-1:0] push_idx,
    input  logic [IW-1:0] head_next,
    output logic [IW-1:0] head,
    output logic [CW-1:0] cnt,
    output logic          empty,
    output logic          link_we,
    output logic [IW-1:0] link_addr,
    output logic [IW-1:0] link_data
);

    logic [IW-1:0] tail;

    // Link the old tail to a released slot unless the chain ends up empty first.
    always_comb begin
        empty     = (cnt == '0);
        link_we   = push && !empty && !(pop && cnt == CW'(1));
        link_addr = tail;
        link_data = push_idx;
    end

    // Head, tail and count update for pop, push or both.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head <= '0;
            tail <= IW'(NB - 1);
            cnt  <= CW'(NB);
        end else begin
            unique case ({pop, push})
                2'b10: begin
                    head <= head_next;
                    cnt  <= cnt - CW'(1);
                end
                2'b01: begin
                    if (empty) head <= push_idx;
                    tail <= push_idx;
                    cnt  <= cnt + CW'(1);
                end
                2'b11: begin
                    head <= (cnt == CW'(1)) ? push_idx : head_next;
                    tail <= push_idx;
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/mqb_port_lists.sv
// Per-port queue chains: head, tail, occupancy and read-open state.
// Appends a written slot to a port's tail, removes a read port's head.
// Assumes: wr_acc/rd_acc are already qualified by the top (slot free,
// port non-empty and open); port ids are in range.
module mqb_port_lists #(
    parameter int NP = 4,
    parameter int IW = 4,
    parameter int PW = 2,
    parameter int CW = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_acc,
    input  logic [PW-1:0]    wr_port,
    input  logic [IW-1:0]    wr_idx,
    input  logic             rd_acc,
    input  logic [PW-1:0]    rd_port,
    input  logic [IW-1:0]    rd_head_next,
    input  logic [NP*CW-1:0] start_lvl,
    output logic [IW-1:0]    rd_head,
    output logic [NP*CW-1:0] occ_flat,
    output logic [NP-1:0]    open_q,
    output logic             link_we,
    output logic [IW-1:0]    link_addr,
    output logic [IW-1:0]    link_data
);

    logic [IW-1:0] head_q [NP];
    logic [IW-1:0] tail_q [NP];
    logic [CW-1:0] occ_q  [NP];
    logic [CW-1:0] occ_nx [NP];
    logic [CW-1:0] lvl_eff[NP];
    logic [NP-1:0] wr_here;
    logic [NP-1:0] rd_here;

    genvar gp;
    generate
        for (gp = 0; gp < NP; gp++) begin : g_port
            // Decode this port's share of the traffic and its next occupancy.
            always_comb begin
                wr_here[gp] = wr_acc && (wr_port == PW'(gp));
                rd_here[gp] = rd_acc && (rd_port == PW'(gp));
                occ_nx[gp]  = occ_q[gp] + CW'(wr_here[gp]) - CW'(rd_here[gp]);
                lvl_eff[gp] = (start_lvl[gp*CW +: CW] == '0) ? CW'(1)
                                                             : start_lvl[gp*CW +: CW];
                occ_flat[gp*CW +: CW] = occ_q[gp];
            end
        end
    endgenerate

    // Port-side link write and current read head.
    always_comb begin
        rd_head   = head_q[rd_port];
        link_we   = wr_acc && (occ_q[wr_port] != '0);
        link_addr = tail_q[wr_port];
        link_data = wr_idx;
    end

    // Chain ends, occupancy and read-open state of every port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int p = 0; p < NP; p++) begin
                head_q[p] <= '0;
                tail_q[p] <= '0;
                occ_q[p]  <= '0;
            end
            open_q <= '0;
        end else begin
            for (int p = 0; p < NP; p++) begin
                if (wr_here[p]) tail_q[p] <= wr_idx;
                if (rd_here[p]) begin
                    head_q[p] <= (wr_here[p] && occ_q[p] == CW'(1)) ? wr_idx : rd_head_next;
                end else if (wr_here[p] && occ_q[p] == '0) begin
                    head_q[p] <= wr_idx;
                end
                occ_q[p]  <= occ_nx[p];
                open_q[p] <= (occ_nx[p] == '0) ? 1'b0
                                               : (open_q[p] || occ_nx[p] >= lvl_eff[p]);
            end
        end
    end

endmodule

// File: rtl/mq_shared_buf.sv
// Top: multi-port ingress buffer over a shared slot pool.
// Qualifies writes and reads, drives the free chain, port chains,
// next-pointer memory and payload memory, and registers read data.
// Assumes: one write and one read request at most per cycle.
module mq_shared_buf
    import mqb_pkg::*;
#(
    parameter int NUM_PORTS = 4,
    parameter int NUM_BUFS  = 16,
    parameter int DATA_W    = 16
) (
    input  logic                                      clk,
    input  logic                                      rst_n,
    input  logic [NUM_PORTS-1:0]                      port_en,
    input  logic [NUM_PORTS*count_bits(NUM_BUFS)-1:0] start_lvl,
    input  logic                                      wr_valid,
    input  logic [bits_for(NUM_PORTS)-1:0]            wr_port,
    input  logic [DATA_W-1:0]                         wr_data,
    input  logic                                      rd_req,
    input  logic [bits_for(NUM_PORTS)-1:0]            rd_port,
    output logic                                      rd_valid,
    output logic [DATA_W-1:0]                         rd_data,
    output logic [NUM_PORTS-1:0]                      port_empty,
    output logic [NUM_PORTS*count_bits(NUM_BUFS)-1:0] port_occ,
    output logic                                      overflow
);

    localparam int PW = bits_for(NUM_PORTS);
    localparam int IW = bits_for(NUM_BUFS);
    localparam int CW = count_bits(NUM_BUFS);

    logic          wr_ok, wr_acc, rd_acc;
    logic [IW-1:0] free_head, free_head_next;
    logic [CW-1:0] free_cnt;
    logic          free_empty;
    logic [IW-1:0] rd_head, rd_head_next;
    logic [NUM_PORTS-1:0] port_open;
    logic          fa_we, pb_we;
    logic [IW-1:0] fa_addr, fa_data, pb_addr, pb_data;
    logic [DATA_W-1:0] slot_word;

    // Request qualification against pool, port enable, occupancy and open state.
    always_comb begin
        wr_ok  = wr_valid && (int'(wr_port) < NUM_PORTS) && port_en[wr_port];
        wr_acc = wr_ok && !free_empty;
        rd_acc = rd_req && (int'(rd_port) < NUM_PORTS) &&
                 (port_occ[rd_port*CW +: CW] != '0) && port_open[rd_port];
    end

    mqb_free_pool #(.NB(NUM_BUFS), .IW(IW), .CW(CW)) u_free (
        .clk       (clk),
        .rst_n     (rst_n),
        .pop       (wr_acc),
        .push      (rd_acc),
        .push_idx  (rd_head),
        .head_next (free_head_next),
        .head      (free_head),
        .cnt       (free_cnt),
        .empty     (free_empty),
        .link_we   (fa_we),
        .link_addr (fa_addr),
        .link_data (fa_data)
    );

    mqb_port_lists #(.NP(NUM_PORTS), .IW(IW), .PW(PW), .CW(CW)) u_ports (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_acc       (wr_acc),
        .wr_port      (wr_port),
        .wr_idx       (free_head),
        .rd_acc       (rd_acc),
        .rd_port      (rd_port),
        .rd_head_next (rd_head_next),
        .start_lvl    (start_lvl),
        .rd_head      (rd_head),
        .occ_flat     (port_occ),
        .open_q       (port_open),
        .link_we      (pb_we),
        .link_addr    (pb_addr),
        .link_data    (pb_data)
    );

    mqb_link_ram #(.NB(NUM_BUFS), .IW(IW)) u_link (
        .clk     (clk),
        .rst_n   (rst_n),
        .wa_en   (fa_we),
        .wa_addr (fa_addr),
        .wa_data (fa_data),
        .wb_en   (pb_we),
        .wb_addr (pb_addr),
        .wb_data (pb_data),
        .ra_addr (free_head),
        .ra_data (free_head_next),
        .rb_addr (rd_head),
        .rb_data (rd_head_next)
    );

    mqb_payload_ram #(.NB(NUM_BUFS), .DW(DATA_W), .IW(IW)) u_data (
        .clk   (clk),
        .we    (wr_acc),
        .waddr (free_head),
        .wdata (wr_data),
        .raddr (rd_head),
        .rdata (slot_word)
    );

    genvar ge;
    generate
        for (ge = 0; ge < NUM_PORTS; ge++) begin : g_empty
            // Per-port empty flag from occupancy.
            always_comb port_empty[ge] = (port_occ[ge*CW +: CW] == '0);
        end
    endgenerate

    // Read return register and sticky lost-write flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
            overflow <= 1'b0;
        end else begin
            rd_valid <= rd_acc;
            if (rd_acc) rd_data <= slot_word;
            if (wr_ok && free_empty) overflow <= 1'b1;
        end
    end

endmodule

// File: rtl/mq_shared_buf_chk.sv
// Checker for mq_shared_buf, attached by bind below.
// Assumes: free_cnt is the top's internal free-slot count.
module mq_shared_buf_chk #(
    parameter int NUM_PORTS = 4,
    parameter int NUM_BUFS  = 16,
    parameter int PW        = 2,
    parameter int CW        = 5
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [NUM_PORTS-1:0]  port_en,
    input logic                  wr_valid,
    input logic [PW-1:0]         wr_port,
    input logic                  rd_req,
    input logic [PW-1:0]         rd_port,
    input logic                  rd_valid,
    input logic [NUM_PORTS-1:0]  port_empty,
    input logic [NUM_PORTS*CW-1:0] port_occ,
    input logic                  overflow,
    input logic [CW-1:0]         free_cnt
);

    logic [CW-1:0] occ_a [NUM_PORTS];
    int            total;

    // Unpack occupancies and total the slots in use plus free.
    always_comb begin
        total = int'(free_cnt);
        for (int p = 0; p < NUM_PORTS; p++) begin
            occ_a[p] = port_occ[p*CW +: CW];
            total    = total + int'(occ_a[p]);
        end
    end

    assert_pool_conserved_R4: assert property (@(posedge clk) disable iff (!rst_n)
        total == NUM_BUFS);

    assert_read_needs_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(rd_req));

    assert_no_read_on_empty_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && port_empty[rd_port]) |=> !rd_valid);

    assert_no_overflow_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |=> overflow);

    assert_disabled_port_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && !port_en[wr_port] && !rd_req) |=>
        (occ_a[$past(wr_port)] == $past(occ_a[wr_port])));

endmodule

bind mq_shared_buf mq_shared_buf_chk #(
    .NUM_PORTS (NUM_PORTS),
    .NUM_BUFS  (NUM_BUFS),
    .PW        (PW),
    .CW        (CW)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .port_en    (port_en),
    .wr_valid   (wr_valid),
    .wr_port    (wr_port),
    .rd_req     (rd_req),
    .rd_port    (rd_port),
    .rd_valid   (rd_valid),
    .port_empty (port_empty),
    .port_occ   (port_occ),
    .overflow   (overflow),
    .free_cnt   (free_cnt)
);

// File: tb/tb_mq_shared_buf.sv
module tb_mq_shared_buf;

    localparam int CLK_P = 10;
    localparam int NP    = 4;
    localparam int NB    = 16;
    localparam int DW    = 16;
    localparam int PW    = 2;
    localparam int CW    = 5;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NP-1:0]     port_en = '1;
    logic [NP*CW-1:0]  start_lvl = '0;
    logic              wr_valid = 1'b0;
    logic [PW-1:0]     wr_port = '0;
    logic [DW-1:0]     wr_data = '0;
    logic              rd_req = 1'b0;
    logic [PW-1:0]     rd_port = '0;
    logic              rd_valid;
    logic [DW-1:0]     rd_data;
    logic [NP-1:0]     port_empty;
    logic [NP*CW-1:0]  port_occ;
    logic              overflow;

    mq_shared_buf #(.NUM_PORTS(NP), .NUM_BUFS(NB), .DATA_W(DW)) dut (
        .clk(clk), .rst_n(rst_n), .port_en(port_en), .start_lvl(start_lvl),
        .wr_valid(wr_valid), .wr_port(wr_port), .wr_data(wr_data),
        .rd_req(rd_req), .rd_port(rd_port), .rd_valid(rd_valid), .rd_data(rd_data),
        .port_empty(port_empty), .port_occ(port_occ), .overflow(overflow)
    );

    always #(CLK_P/2) clk = ~clk;

    int checks = 0;
    int fails  = 0;

    logic [DW-1:0] mq [NP][$];
    bit            open_m [NP];
    int            lvl_m  [NP];
    bit            ovf_m;
    bit            exp_rv;
    logic [DW-1:0] exp_rd;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int pool_used();
        int s = 0;
        for (int p = 0; p < NP; p++) s += mq[p].size();
        return s;
    endfunction

    task automatic set_lvl(input int p, input int v);
        lvl_m[p] = v;
        start_lvl[p*CW +: CW] = CW'(v);
    endtask

    task automatic check_state(input string tag);
        chk(rd_valid == exp_rv, {tag, " R2 rd_valid"}, rd_valid, exp_rv);
        if (exp_rv) chk(rd_data == exp_rd, {tag, " R2 rd_data"}, rd_data, exp_rd);
        chk(overflow == ovf_m, {tag, " R3 overflow"}, overflow, ovf_m);
        for (int p = 0; p < NP; p++) begin
            chk(int'(port_occ[p*CW +: CW]) == mq[p].size(), {tag, " R9 occupancy"},
                port_occ[p*CW +: CW], mq[p].size());
            chk(port_empty[p] == (mq[p].size() == 0), {tag, " R9 empty"},
                port_empty[p], mq[p].size() == 0);
        end
    endtask

    // Applies one cycle of stimulus at a falling edge, updates the model,
    // then checks the registered outputs at the next falling edge.
    task automatic step(input string tag, input bit wv, input int wp, input logic [DW-1:0] wd,
                        input bit rr, input int rp);
        int free_before;
        wr_valid = wv; wr_port = PW'(wp); wr_data = wd;
        rd_req = rr;   rd_port = PW'(rp);
        free_before = NB - pool_used();
        exp_rv = rr && mq[rp].size() > 0 && open_m[rp];
        if (exp_rv) exp_rd = mq[rp].pop_front();
        if (wv && port_en[wp]) begin
            if (free_before > 0) mq[wp].push_back(wd);
            else ovf_m = 1'b1;
        end
        for (int p = 0; p < NP; p++) begin
            int le = (lvl_m[p] == 0) ? 1 : lvl_m[p];
            int n  = mq[p].size();
            open_m[p] = (n == 0) ? 1'b0 : (open_m[p] || n >= le);
        end
        @(negedge clk);
        check_state(tag);
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    endtask

    initial begin
        #(CLK_P * 200000);
        checks++; fails++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        for (int p = 0; p < NP; p++) begin
            set_lvl(p, 1);
            open_m[p] = 1'b0;
        end
        ovf_m = 1'b0; exp_rv = 1'b0; exp_rd = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check_state("R1 reset");

        // R4: one port takes the whole pool
        for (int i = 0; i < NB; i++) step("R4 fill", 1, 0, DW'(16'h100 + i), 0, 0);
        chk(int'(port_occ[0 +: CW]) == NB, "R4 full single port", port_occ[0 +: CW], NB);
        // R3: overflow on full pool, port 1 untouched
        step("R3 overflow", 1, 1, 16'hdead, 0, 0);
        // R8: same-cycle read and write at full pool, write dropped
        step("R8 full same cycle", 1, 2, 16'hbeef, 1, 0);
        // R4/R8: freed slots reused by other ports
        for (int i = 0; i < 8; i++) step("R4 reuse", 1, 1, DW'(16'h200 + i), 1, 0);
        // R5: read of empty port
        step("R5 empty read", 0, 0, 0, 1, 3);
        while (mq[0].size() > 0) step("R2 drain0", 0, 0, 0, 1, 0);
        while (mq[1].size() > 0) step("R2 drain1", 0, 0, 0, 1, 1);
        // R6: start level gating
        set_lvl(2, 3);
        step("R6 w1", 1, 2, 16'h301, 0, 0);
        step("R6 w2", 1, 2, 16'h302, 0, 0);
        step("R6 gated read", 0, 0, 0, 1, 2);
        step("R6 w3", 1, 2, 16'h303, 0, 0);
        step("R6 open read", 0, 0, 0, 1, 2);
        step("R6 stays open", 0, 0, 0, 1, 2);
        step("R6 last", 0, 0, 0, 1, 2);
        set_lvl(2, 0);
        step("R6 level zero", 1, 2, 16'h304, 0, 0);
        step("R6 level zero read", 0, 0, 0, 1, 2);
        // R7: disabled port ignores writes, still drains
        step("R7 prep", 1, 1, 16'h401, 0, 0);
        port_en[1] = 1'b0;
        step("R7 ignored write", 1, 1, 16'h402, 0, 0);
        step("R7 drain disabled", 0, 0, 0, 1, 1);
        port_en[1] = 1'b1;
        // R8: same port, occupancy one, read and write together
        step("R8 prep", 1, 3, 16'h501, 0, 0);
        step("R8 same port", 1, 3, 16'h502, 1, 3);
        step("R8 same port next", 1, 3, 16'h503, 1, 3);
        step("R8 tail read", 0, 0, 0, 1, 3);

        // Random phase
        for (int c = 0; c < 5000; c++) begin
            int wp = int'($urandom_range(NP - 1));
            int rp = int'($urandom_range(NP - 1));
            bit wv = ($urandom_range(99) < 55);
            bit rr = ($urandom_range(99) < 50);
            if ($urandom_range(199) == 0) set_lvl(int'($urandom_range(NP - 1)), int'($urandom_range(4)));
            if ($urandom_range(99) == 0) port_en = NP'($urandom) | NP'(1);
            step("R8 random", wv, wp, DW'($urandom), rr, rp);
        end
        finish_run();
    end

endmodule